// File: doc/BRIEF.md
# On-Off Keyed Two-Frame Code Player

This block drives the one-bit keying input of an RF switch so that a stored code is replayed as on-off keying. Every code consists of two frames of equal length, A and B. A 1 bit turns the carrier on and a 0 bit turns it off. Several codes are held in a parameter library, and a select input chooses which code plays.

While `play_en` is held high, the block sends frame A and then waits a long gap. It then sends frame B and waits another gap, and the pair repeats. Bit time and gap length are parameters given in nanoseconds. Each one is rounded to a whole number of clock cycles, so the timing error per bit stays below one clock. With the defaults, the block produces 83-bit frames, a bit time of about 504 µs and a gap of about 100.4 ms.

If `play_en` is dropped part way through, the current pair, including its closing gap, still finishes. The select input is read only at the start of each pair. A busy flag and a start-of-frame strobe are provided for debug. The carrier, oscillator, antenna and any host loading of codes are outside this block.

Top module: `ook_pair_serializer`

## Requirements
- R1: After reset, `rf_key`, `busy` and `frame_start` are all low.
- R2: Code k occupies library bits [k*2F+2F-1 : k*2F]. Frame A is the upper F bits and frame B is the lower F bits. Each frame is sent most significant bit first, with `rf_key` high for a 1 bit and low for a 0 bit.
- R3: Each bit is held for exactly BIT_CYC clock cycles, where BIT_CYC = round(CLK_HZ * BIT_NS / 1e9).
- R4: After each frame, `rf_key` stays low for exactly GAP_CYC cycles, where GAP_CYC = round(CLK_HZ * GAP_NS / 1e9).
- R5: The output sequence is frame A, gap, frame B, gap. While `play_en` is high at the end of the second gap, a new pair begins in the very next cycle with no extra delay.
- R6: A pair begins in the cycle after the clock edge at which an idle block samples `play_en` high. A single-cycle pulse on `play_en` is enough to play a whole pair.
- R7: If `play_en` falls during a pair, that pair completes through its final gap. The block then returns to idle, with `busy` low.
- R8: `code_sel` is sampled only at the edge that starts a pair. Changes during a pair have no effect until the next pair.
- R9: `frame_start` is high for exactly one cycle, namely the first cycle of bit 0 of each frame, and at no other time.
- R10: `busy` is high from the first cycle of a pair through the last cycle of its closing gap. Whenever `busy` is low, `rf_key` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_en | input | 1 | Play request; held high to repeat pairs |
| code_sel | input | SEL_W | Library index of the code to play |
| rf_key | output | 1 | Keying output to the RF switch |
| busy | output | 1 | A pair is in progress |
| frame_start | output | 1 | One-cycle strobe at the first bit of each frame |

## Verification
Two decisions can fall on the same edge: the end of the closing gap, and either the release of `play_en` or a change of `code_sel`. The bench changes the select three cycles before a pair ends and checks that the following pair plays the new code without any break in timing. It also releases `play_en` partway through frame A and with a one-cycle pulse, and checks that a complete pair still plays before `busy` falls. Every cycle is compared with a cycle-position model of the pair, covering all library codes in a reduced configuration.

// File: rtl/ook_pkg.sv
`timescale 1ns/1ps
package ook_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME_A,
    ST_GAP_A,
    ST_FRAME_B,
    ST_GAP_B
  } ook_state_e;

  // Round a duration in ns to whole clock cycles, minimum one.
  function automatic int ns_to_cycles(longint clk_hz, longint dur_ns);
    longint c;
    c = (clk_hz * dur_ns + 64'd500_000_000) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/ook_interval_timer.sv
`timescale 1ns/1ps
module ook_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || last) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ook_frame_shifter.sv
`timescale 1ns/1ps
module ook_frame_shifter #(
  parameter int F = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [F-1:0] frame_in,
  input  logic         shift,
  output logic         msb,
  output logic         last_bit
);
  localparam int IW = (F > 1) ? $clog2(F) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(F - 1);

  logic [F-1:0]  sh;
  logic [IW-1:0] idx;

  assign msb      = sh[F-1];
  assign last_bit = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= frame_in;
      idx <= '0;
    end else if (shift) begin
      sh  <= {sh[F-2:0], 1'b0};
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/ook_pair_ctrl.sv
`timescale 1ns/1ps
module ook_pair_ctrl
  import ook_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       play_en,
  input  logic       seg_last,
  input  logic       last_bit,
  output ook_state_e state,
  output logic       load_pair,
  output logic       load_b,
  output logic       shift,
  output logic       sof_q
);
  ook_state_e nxt;

  always_comb begin
    nxt       = state;
    load_pair = 1'b0;
    load_b    = 1'b0;
    shift     = 1'b0;
    unique case (state)
      ST_IDLE: if (play_en) begin
        load_pair = 1'b1;
        nxt       = ST_FRAME_A;
      end
      ST_FRAME_A: if (seg_last) begin
        if (last_bit) nxt = ST_GAP_A;
        else          shift = 1'b1;
      end
      ST_GAP_A: if (seg_last) begin
        load_b = 1'b1;
        nxt    = ST_FRAME_B;
      end
      ST_FRAME_B: if (seg_last) begin
        if (last_bit) nxt = ST_GAP_B;
        else          shift = 1'b1;
      end
      ST_GAP_B: if (seg_last) begin
        if (play_en) begin
          load_pair = 1'b1;
          nxt       = ST_FRAME_A;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sof_q <= 1'b0;
    end else begin
      state <= nxt;
      sof_q <= load_pair | load_b;
    end
  end
endmodule

// File: rtl/ook_pair_serializer.sv
`timescale 1ns/1ps
module ook_pair_serializer
  import ook_pkg::*;
#(
  parameter int      FRAME_BITS = 83,
  parameter int      NUM_CODES  = 4,
  parameter longint  CLK_HZ     = 50_000_000,
  parameter longint  BIT_NS     = 504_000,
  parameter longint  GAP_NS     = 100_400_000,
  parameter int      SEL_W      = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1,
  parameter logic [NUM_CODES*2*FRAME_BITS-1:0] CODE_LIB =
    {(NUM_CODES*2*FRAME_BITS/4){4'b1001}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             play_en,
  input  logic [SEL_W-1:0] code_sel,
  output logic             rf_key,
  output logic             busy,
  output logic             frame_start
);
  localparam int F       = FRAME_BITS;
  localparam int BIT_CYC = ns_to_cycles(CLK_HZ, BIT_NS);
  localparam int GAP_CYC = ns_to_cycles(CLK_HZ, GAP_NS);
  localparam int MAX_CYC = (BIT_CYC > GAP_CYC) ? BIT_CYC : GAP_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] BIT_LIM = TW'(BIT_CYC - 1);
  localparam logic [TW-1:0] GAP_LIM = TW'(GAP_CYC - 1);

  logic [F-1:0] frame_a [NUM_CODES];
  logic [F-1:0] frame_b [NUM_CODES];

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_lib
    assign frame_a[k] = CODE_LIB[k*2*F + F +: F];
    assign frame_b[k] = CODE_LIB[k*2*F     +: F];
  end

  ook_state_e       state;
  logic             load_pair, load_b, shift, sof_q;
  logic             seg_last, last_bit, msb;
  logic             in_gap, in_frame;
  logic [SEL_W-1:0] code_q;
  logic [SEL_W-1:0] sel_safe;
  logic [F-1:0]     frame_mux;

  assign in_gap   = (state == ST_GAP_A)   || (state == ST_GAP_B);
  assign in_frame = (state == ST_FRAME_A) || (state == ST_FRAME_B);
  assign sel_safe = (int'(code_sel) < NUM_CODES) ? code_sel : '0;
  assign frame_mux = load_pair ? frame_a[sel_safe] : frame_b[code_q];

  always_ff @(posedge clk) begin
    if (!rst_n)         code_q <= '0;
    else if (load_pair) code_q <= sel_safe;
  end

  ook_pair_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .play_en   (play_en),
    .seg_last  (seg_last),
    .last_bit  (last_bit),
    .state     (state),
    .load_pair (load_pair),
    .load_b    (load_b),
    .shift     (shift),
    .sof_q     (sof_q)
  );

  ook_interval_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state == ST_IDLE),
    .limit (in_gap ? GAP_LIM : BIT_LIM),
    .last  (seg_last)
  );

  ook_frame_shifter #(.F(F)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_pair | load_b),
    .frame_in (frame_mux),
    .shift    (shift),
    .msb      (msb),
    .last_bit (last_bit)
  );

  assign rf_key      = in_frame & msb;
  assign busy        = (state != ST_IDLE);
  assign frame_start = sof_q;
endmodule

// File: rtl/ook_pair_serializer_chk.sv
`timescale 1ns/1ps
module ook_pair_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic rf_key,
  input logic busy,
  input logic frame_start,
  input logic in_gap
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rf_key);
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  a_r9_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> busy);
  a_r4_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> !rf_key);
  a_r7_end_from_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy ##1 !busy) |-> $past(in_gap));
  a_r6_start_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy ##1 busy) |-> frame_start);
endmodule

bind ook_pair_serializer ook_pair_serializer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rf_key      (rf_key),
  .busy        (busy),
  .frame_start (frame_start),
  .in_gap      (in_gap)
);

// File: tb/ook_pair_serializer_tb.sv
`timescale 1ns/1ps
module ook_pair_serializer_tb;
  localparam int F   = 8;
  localparam int NC  = 4;
  localparam int BC  = 3;   // 1 GHz * 3 ns
  localparam int GC  = 5;   // 1 GHz * 5 ns
  localparam int FL  = F * BC;
  localparam int P   = 2 * FL + 2 * GC;
  localparam logic [NC*2*F-1:0] LIB = 64'hA5C3_3C5A_F00F_1E87;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       play_en = 1'b0;
  logic [1:0] code_sel = '0;
  logic       rf_key, busy, frame_start;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ook_pair_serializer #(
    .FRAME_BITS(F), .NUM_CODES(NC), .CLK_HZ(1_000_000_000),
    .BIT_NS(3), .GAP_NS(5), .CODE_LIB(LIB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .code_sel(code_sel),
    .rf_key(rf_key), .busy(busy), .frame_start(frame_start)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_key(int c, int p);
    logic [F-1:0] a, b;
    a = LIB[c*2*F + F +: F];
    b = LIB[c*2*F +: F];
    if (p < FL)                return a[F-1 - p/BC];
    else if (p < FL + GC)      return 1'b0;
    else if (p < 2*FL + GC)    return b[F-1 - (p-FL-GC)/BC];
    else                       return 1'b0;
  endfunction

  // Each cycle compared to the model (R2 R3 R4 R5 R6 R8 R9 R10).
  task automatic run(int n, int c1, int c2, int drop_at, int sel_at, int sel_val);
    for (int t = 0; t < n; t++) begin
      int p, c;
      @(negedge clk);
      p = t % P;
      c = (t < P) ? c1 : c2;
      chk("R2/R3/R4/R5/R8 rf_key", rf_key, exp_key(c, p));
      chk("R9 frame_start", frame_start, (p == 0) || (p == FL + GC));
      chk("R10 busy", busy, 1'b1);
      if (t == drop_at) play_en = 1'b0;
      if (t == sel_at)  code_sel = 2'(sel_val);
    end
  endtask

  task automatic idle_check(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R7 busy after pair", busy, 1'b0);
      chk("R10 rf_key idle", rf_key, 1'b0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rf_key", rf_key, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 frame_start", frame_start, 1'b0);
    rst_n = 1'b1;
    idle_check(3);

    // Every code; select changed (R8) and enable dropped (R7) mid frame A.
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      code_sel = 2'(c);
      play_en  = 1'b1;
      run(P, c, c, 10, 5, c ^ 1);
      idle_check(3);
    end

    // One-cycle enable pulse still plays a full pair (R6, R7).
    @(negedge clk);
    code_sel = 2'd3;
    play_en  = 1'b1;
    run(P, 3, 3, 0, -1, 0);
    idle_check(2);

    // Continuous play; select changes near end of pair, next pair uses it (R5, R8).
    @(negedge clk);
    code_sel = 2'd2;
    play_en  = 1'b1;
    run(2*P, 2, 1, P + 7, P - 3, 1);
    idle_check(10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule